// File: doc/BRIEF.md
# NAND Sector Hamming Code Corrector

This block checks one 512-byte flash sector using two 24-bit check codes. The first code is the one read from the spare area. The second is the one recomputed over the sector data as it was read. The three code bytes are packed little-endian, so code byte k sits in bits 8k+7:8k. The two codes are XORed to form a syndrome.

The syndrome is split into twelve adjacent bit pairs. If every pair differs in exactly one bit, one data bit has flipped. The block then decodes which byte and which bit it is. A syndrome with a single set bit that fails this pair test means the stored code itself is damaged, and the data is left alone. A zero syndrome is clean. Anything else cannot be repaired.

With the repair option enabled, the block fixes a correctable error itself. It reads the faulty byte from a sector buffer, flips the bit and writes the byte back, all before signalling completion.

A small sequencer with three states drives the transaction:
- `SEQ_IDLE` accepts a strobe.
- It moves to `SEQ_FETCH` only for a correctable result while repair is enabled. Every other accepted result finishes at once.
- `SEQ_FETCH` issues the buffer read and always moves to `SEQ_STORE`.
- `SEQ_STORE` writes the corrected byte and always returns to `SEQ_IDLE`, pulsing done.

Top module: `nand_ecc_fixer`

## Requirements
- R1: A syndrome of zero gives status 00, and done is high in the cycle right after the clock edge that sampled `code_valid`.
- R2: A syndrome is correctable when syndrome bits 2k and 2k+1 differ for every k from 0 to 11. It then gives status 01.
- R3: For status 01, `err_bit` is {syndrome[23], syndrome[21], syndrome[19]}, with bit 19 as the LSB. For any other status it is 0.
- R4: For status 01, `err_byte` bits 8 down to 0 come from syndrome bits 17, 7, 5, 3, 1, 15, 13, 11, 9 in that order. For any other status it is 0.
- R5: A nonzero syndrome that fails the pair test but has exactly one bit set gives status 10. The buffer is not accessed.
- R6: Every other nonzero syndrome gives status 11. The buffer is not accessed.
- R7: With `APPLY_FIX`=1 and status 01, the following happens in order:
  - `buf_rd_en` is high for one cycle, in the cycle after the sampling edge, at address `err_byte`.
  - The buffer returns the data one cycle after the read.
  - In the next cycle, `buf_wr_en` is high for one cycle at the same address, with data equal to the read byte XOR (1 << `err_bit`).
  - done is high in the cycle after the write.
- R8: done is high for one cycle per accepted strobe. `status`, `err_byte` and `err_bit` update at the accepting edge and hold until the next accepted strobe.
- R9: A `code_valid` seen while a read-modify-write is in progress is ignored.
- R10: During reset, done, status, `buf_rd_en` and `buf_wr_en` are all 0.
- R11: With `APPLY_FIX`=0, no buffer strobe is ever raised. Every strobe, including a correctable one, completes one cycle later, and strobes may arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | Both codes are valid this cycle |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code recomputed over the sector |
| done | output | 1 | Result complete, one-cycle pulse |
| status | output | 2 | 00 clean, 01 data fixed, 10 code-only fault, 11 uncorrectable |
| err_byte | output | 9 | Byte index of the flipped bit |
| err_bit | output | 3 | Bit index within that byte |
| buf_rd_en | output | 1 | Sector buffer read strobe |
| buf_wr_en | output | 1 | Sector buffer write strobe |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_wr_data | output | 8 | Corrected byte to write |
| buf_rd_data | input | 8 | Buffer read data, one cycle after `buf_rd_en` |

## Verification
Count each stimulus from the clock edge that samples the strobe. Status and indices change at that edge and can be read in the same cycle. When no repair is needed, done follows in that cycle too. For a repair, the read strobe is due in that cycle, the write strobe one cycle later and done two cycles later. The bench keeps these due cycles in its reference model and compares every output on each falling edge. It also checks the buffer contents in the done cycle.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    localparam int CODE_W       = 24;
    localparam int PAIR_N       = CODE_W / 2;
    localparam int SECTOR_BYTES = 512;
    localparam int IDX_W        = $clog2(SECTOR_BYTES);
    localparam int BIT_W        = 3;

    typedef enum logic [1:0] {
        ST_CLEAN      = 2'b00,
        ST_DATA_FIXED = 2'b01,
        ST_CODE_FIXED = 2'b10,
        ST_FATAL      = 2'b11
    } ecc_status_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FETCH,
        SEQ_STORE
    } seq_state_e;

    typedef struct packed {
        ecc_status_e             status;
        logic [IDX_W-1:0]        byte_idx;
        logic [BIT_W-1:0]        bit_idx;
    } ecc_verdict_t;

endpackage

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode
    import ecc_fix_pkg::*;
(
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    output ecc_verdict_t      verdict
);

    // Syndrome positions feeding each index bit, LSB first.
    localparam int BYTE_SRC [IDX_W] = '{9, 11, 13, 15, 1, 3, 5, 7, 17};
    localparam int BIT_SRC  [BIT_W] = '{19, 21, 23};

    logic [CODE_W-1:0] syn;
    logic [PAIR_N-1:0] pair_split;
    logic [IDX_W-1:0]  byte_raw;
    logic [BIT_W-1:0]  bit_raw;
    logic              all_split;
    logic              lone_bit;

    assign syn = stored_code ^ calc_code;

    generate
        for (genvar k = 0; k < PAIR_N; k++) begin : g_pair
            assign pair_split[k] = syn[2*k] ^ syn[2*k+1];
        end
        for (genvar i = 0; i < IDX_W; i++) begin : g_byte
            assign byte_raw[i] = syn[BYTE_SRC[i]];
        end
        for (genvar j = 0; j < BIT_W; j++) begin : g_bit
            assign bit_raw[j] = syn[BIT_SRC[j]];
        end
    endgenerate

    assign all_split = &pair_split;
    assign lone_bit  = $onehot(syn);

    always_comb begin
        verdict.byte_idx = '0;
        verdict.bit_idx  = '0;
        if (syn == '0) begin
            verdict.status = ST_CLEAN;
        end else if (all_split) begin
            verdict.status   = ST_DATA_FIXED;
            verdict.byte_idx = byte_raw;
            verdict.bit_idx  = bit_raw;
        end else if (lone_bit) begin
            verdict.status = ST_CODE_FIXED;
        end else begin
            verdict.status = ST_FATAL;
        end
    end

    // R5: a code-only fault never coincides with a correctable pattern.
    always_comb begin
        if (all_split) begin
            p_split_not_lone_r5: assert ($countones(syn) == PAIR_N);
        end
    end

endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
    import ecc_fix_pkg::*;
#(
    parameter bit APPLY_FIX = 1'b1,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  ecc_verdict_t      verdict_in,
    output ecc_verdict_t      verdict_q,
    output logic              done,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [IDX_W-1:0]  buf_addr,
    output logic [DATA_W-1:0] buf_wr_data,
    input  logic [DATA_W-1:0] buf_rd_data
);

    localparam logic [DATA_W-1:0] ONE_HOT_LSB = {{(DATA_W-1){1'b0}}, 1'b1};

    seq_state_e state, state_nxt;
    logic       accept;
    logic       done_nxt;
    logic       wants_fix;

    assign wants_fix = APPLY_FIX && (verdict_in.status == ST_DATA_FIXED);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nxt   = state;
        accept      = 1'b0;
        done_nxt    = 1'b0;
        buf_rd_en   = 1'b0;
        buf_wr_en   = 1'b0;
        buf_addr    = verdict_q.byte_idx;
        buf_wr_data = buf_rd_data ^ (ONE_HOT_LSB << verdict_q.bit_idx);
        unique case (state)
            SEQ_IDLE: begin
                if (in_valid) begin
                    accept = 1'b1;
                    if (wants_fix) begin
                        state_nxt = SEQ_FETCH;
                    end else begin
                        done_nxt = 1'b1;
                    end
                end
            end
            SEQ_FETCH: begin
                buf_rd_en = 1'b1;
                state_nxt = SEQ_STORE;
            end
            SEQ_STORE: begin
                buf_wr_en = 1'b1;
                done_nxt  = 1'b1;
                state_nxt = SEQ_IDLE;
            end
            default: state_nxt = SEQ_IDLE;
        endcase
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '{status: ST_CLEAN, byte_idx: '0, bit_idx: '0};
            done      <= 1'b0;
        end else begin
            done <= done_nxt;
            if (accept) begin
                verdict_q <= verdict_in;
            end
        end
    end

    p_quick_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && in_valid && !wants_fix) |=> done);

    p_read_then_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> (buf_wr_en && buf_addr == $past(buf_addr)));

    p_read_only_for_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> verdict_q.status == ST_DATA_FIXED);

    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> done);

    p_busy_holds_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_IDLE) |=> $stable(verdict_q));

    p_no_buffer_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !APPLY_FIX |-> (!buf_rd_en && !buf_wr_en));

endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
    import ecc_fix_pkg::*;
#(
    parameter bit APPLY_FIX = 1'b1,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    output logic              done,
    output logic [1:0]        status,
    output logic [IDX_W-1:0]  err_byte,
    output logic [BIT_W-1:0]  err_bit,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [IDX_W-1:0]  buf_addr,
    output logic [DATA_W-1:0] buf_wr_data,
    input  logic [DATA_W-1:0] buf_rd_data
);

    ecc_verdict_t verdict_c;
    ecc_verdict_t verdict_r;

    ecc_syndrome_decode u_decode (
        .stored_code (stored_code),
        .calc_code   (calc_code),
        .verdict     (verdict_c)
    );

    ecc_rmw_seq #(
        .APPLY_FIX (APPLY_FIX),
        .DATA_W    (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (code_valid),
        .verdict_in  (verdict_c),
        .verdict_q   (verdict_r),
        .done        (done),
        .buf_rd_en   (buf_rd_en),
        .buf_wr_en   (buf_wr_en),
        .buf_addr    (buf_addr),
        .buf_wr_data (buf_wr_data),
        .buf_rd_data (buf_rd_data)
    );

    assign status   = verdict_r.status;
    assign err_byte = verdict_r.byte_idx;
    assign err_bit  = verdict_r.bit_idx;

    p_idx_zero_unless_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b01) |-> (err_byte == '0 && err_bit == '0));

    p_write_flips_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $countones(buf_wr_data ^ buf_rd_data) == 1);

endmodule

// File: tb/tb_nand_ecc_fixer.sv
module tb_nand_ecc_fixer;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        v;
    logic [23:0] sc, cc;

    logic        done, rd_en, wr_en;
    logic [1:0]  status;
    logic [8:0]  err_byte, addr;
    logic [2:0]  err_bit;
    logic [7:0]  wr_data, rd_q;

    logic        nf_done, nf_rd, nf_wr;
    logic [1:0]  nf_status;
    logic [8:0]  nf_byte, nf_addr;
    logic [2:0]  nf_bit;
    logic [7:0]  nf_wdata;

    nand_ecc_fixer #(.APPLY_FIX(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .code_valid(v), .stored_code(sc), .calc_code(cc),
        .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
        .buf_rd_en(rd_en), .buf_wr_en(wr_en), .buf_addr(addr),
        .buf_wr_data(wr_data), .buf_rd_data(rd_q));

    nand_ecc_fixer #(.APPLY_FIX(1'b0)) dut_nf (
        .clk(clk), .rst_n(rst_n), .code_valid(v), .stored_code(sc), .calc_code(cc),
        .done(nf_done), .status(nf_status), .err_byte(nf_byte), .err_bit(nf_bit),
        .buf_rd_en(nf_rd), .buf_wr_en(nf_wr), .buf_addr(nf_addr),
        .buf_wr_data(nf_wdata), .buf_rd_data(8'h00));

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference classification built from the requirement text.
    function automatic void classify(input logic [23:0] s, input logic [23:0] c,
                                     output int st, output int by, output int bi);
        logic [23:0] syn;
        bit ok;
        int src [9];
        src = '{9, 11, 13, 15, 1, 3, 5, 7, 17};
        syn = s ^ c;
        by = 0; bi = 0;
        ok = 1;
        for (int k = 0; k < 12; k++) if (syn[2*k] == syn[2*k+1]) ok = 0;
        if (syn == 0) st = 0;
        else if (ok) begin
            st = 1;
            for (int i = 0; i < 9; i++) if (syn[src[i]]) by += (1 << i);
            bi = syn[19] + 2 * syn[21] + 4 * syn[23];
        end else if ($countones(syn) == 1) st = 2;
        else st = 3;
    endfunction

    function automatic logic [23:0] make_syn(int b, int t);
        logic [23:0] s;
        int src [9];
        int bsrc [3];
        src  = '{9, 11, 13, 15, 1, 3, 5, 7, 17};
        bsrc = '{19, 21, 23};
        s = '0;
        for (int i = 0; i < 9; i++) begin s[src[i]] = b[i]; s[src[i]-1] = ~b[i]; end
        for (int j = 0; j < 3; j++) begin s[bsrc[j]] = t[j]; s[bsrc[j]-1] = ~t[j]; end
        return s;
    endfunction

    function automatic string tag_for(int st);
        case (st)
            0: return "R1";
            1: return "R2";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Sector buffer with one-cycle read latency
    logic [7:0] mem [0:511];
    logic [7:0] exp_mem [0:511];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 37 + 5);
        end else begin
            if (rd_en) rd_q <= mem[addr];
            if (wr_en) mem[addr] <= wr_data;
        end
    end

    // Cycle model
    int cyc, due, busy_until, fetch_at;
    int m_st, m_byte, m_bit;
    int nf_due, n_st, n_byte, n_bit;
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; due = -10; busy_until = -10; fetch_at = -10;
            m_st = 0; m_byte = 0; m_bit = 0;
            nf_due = -10; n_st = 0; n_byte = 0; n_bit = 0;
            for (int i = 0; i < 512; i++) exp_mem[i] = 8'(i * 37 + 5);
        end else begin
            cyc++;
            if (v) begin
                classify(sc, cc, n_st, n_byte, n_bit);
                nf_due = cyc;
                if (cyc > busy_until) begin
                    classify(sc, cc, m_st, m_byte, m_bit);
                    if (m_st == 1) begin
                        fetch_at = cyc;
                        due = cyc + 2;
                        busy_until = cyc + 2;
                        exp_mem[m_byte] = exp_mem[m_byte] ^ 8'(1 << m_bit);
                    end else begin
                        due = cyc;
                        busy_until = cyc;
                    end
                end
            end
        end
    end

    // Compare on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R8 done", done, int'(cyc == due));
            chk({tag_for(m_st), " status"}, status, m_st);
            chk("R4 err_byte", err_byte, m_byte);
            chk("R3 err_bit", err_bit, m_bit);
            chk({(m_st == 1) ? "R7" : tag_for(m_st), " rd_en"}, rd_en, int'(cyc == fetch_at));
            chk({(m_st == 1) ? "R7" : tag_for(m_st), " wr_en"}, wr_en, int'(cyc == fetch_at + 1));
            if (wr_en) begin
                chk("R7 wr_addr", addr, m_byte);
                chk("R7 wr_data", wr_data, exp_mem[m_byte]);
            end
            if (done && m_st == 1) chk("R7 buffer byte", mem[m_byte], exp_mem[m_byte]);
            chk("R11 done", nf_done, int'(cyc == nf_due));
            chk("R11 rd_en", nf_rd, 0);
            chk("R11 wr_en", nf_wr, 0);
            chk("R11 status", nf_status, n_st);
            chk("R11 err_byte", nf_byte, n_byte);
            chk("R11 err_bit", nf_bit, n_bit);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic send(logic [23:0] s, logic [23:0] c, int gap);
        @(negedge clk);
        v = 1'b1; sc = s; cc = c;
        @(negedge clk);
        v = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_fix(int b, int t);
        logic [23:0] s;
        s = 24'($urandom);
        send(s, s ^ make_syn(b, t), 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [23:0] base;
        rst_n = 1'b0; v = 1'b0; sc = '0; cc = '0;
        repeat (3) @(negedge clk);
        chk("R10 done", done, 0);
        chk("R10 status", status, 0);
        chk("R10 rd_en", rd_en, 0);
        chk("R10 wr_en", wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        send(24'h123456, 24'h123456, 3);              // R1
        send_fix(0, 0);                               // R2 R3 R4 R7
        send_fix(511, 7);
        send_fix(9'h155, 2);
        send_fix(9'h0AA, 5);
        send_fix(1, 4);
        send_fix(256, 1);
        send(24'h0, 24'h000001, 3);                   // R5
        send(24'hABCDEF, 24'hABCDEF ^ 24'h800000, 3);
        send(24'h000000, 24'h001000, 3);
        send(24'h000000, 24'h000003, 3);              // R6
        send(24'h000000, 24'h000005, 3);
        send(24'h000000, 24'hFFFFFF, 3);

        // R9: strobes during a repair are ignored
        base = 24'h5A5A5A;
        @(negedge clk); v = 1'b1; sc = base; cc = base ^ make_syn(77, 3);
        @(negedge clk); sc = base; cc = base ^ make_syn(300, 6);
        @(negedge clk); sc = base; cc = base;
        @(negedge clk); v = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 byte kept", err_byte, 77);
        chk("R9 bit kept", err_bit, 3);

        // Back-to-back strobes without repair (R1 R8 R11)
        @(negedge clk); v = 1'b1; sc = 24'h1; cc = 24'h1;
        @(negedge clk); cc = 24'h3;
        @(negedge clk); cc = 24'h0;
        @(negedge clk); cc = 24'h1 ^ make_syn(12, 1);
        @(negedge clk); v = 1'b0;
        repeat (4) @(negedge clk);

        for (int n = 0; n < 300; n++) begin
            logic [23:0] s, syn;
            int kind;
            s = 24'($urandom);
            kind = $urandom_range(0, 3);
            case (kind)
                0: syn = '0;
                1: syn = make_syn($urandom_range(0, 511), $urandom_range(0, 7));
                2: syn = 24'(1 << $urandom_range(0, 23));
                default: syn = 24'($urandom);
            endcase
            send(s, s ^ syn, $urandom_range(0, 3));
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule